// File: doc/BRIEF.md
# PWM Rate Strobe Generator

This block turns one master clock into the set of rate strobes that a group of PWM channels counts on. A free-running binary counter produces eleven power-of-two tap strobes, from every master cycle down to one cycle in 1024. Two independent linear dividers, A and B, each pick one of these taps as their input and let through one pulse for every N input pulses. N is an 8-bit factor. A channel can therefore count at any of thirteen rates: the eleven taps, strobe A or strobe B.

Every output is a one-cycle enable pulse in the master clock domain, not a derived clock. All configuration comes from a single 32-bit mode word held steady by the surrounding logic. Divider A reads its factor from bits 7:0 and its tap select from bits 11:8. Divider B reads its factor from bits 23:16 and its tap select from bits 27:24. The remaining bits are unused. There is no data stream, so every pin is a plain control or strobe signal.

Top module: `pwm_rate_gen`

## Requirements
- R1: Tap k (k = 0..10, bit k of `tap_stb`) pulses for exactly one master cycle once every 2^k master cycles. Tap 0 is high on every cycle after reset.
- R2: The taps are phase-nested. On any cycle where tap k pulses, every tap below k also pulses.
- R3: Divider A takes its factor F from mode bits 7:0 and its tap select S from mode bits 11:8. With F in 1..255 and S in 0..10, `stb_a` pulses for one cycle every F * 2^S master cycles, and only on a cycle following a pulse of the selected tap.
- R4: Divider B behaves like divider A, with F taken from mode bits 23:16 and S from mode bits 27:24, and drives `stb_b`.
- R5: A divider whose factor field is 0 never pulses.
- R6: A divider whose tap select field is 11..15 never pulses.
- R7: Any change to a divider's factor or select field restarts that divider's count. With tap 0 selected, the first pulse appears F master cycles after the first clock edge that sees the new value.
- R8: Changing one divider's fields leaves the other divider's pulse spacing unchanged across the write.
- R9: While reset is asserted, all thirteen strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_word | input | 32 | Divider configuration (factor and tap select for A and B) |
| tap_stb | output | 11 | Power-of-two tap strobes; bit k pulses once per 2^k cycles |
| stb_a | output | 1 | Divider A strobe |
| stb_b | output | 1 | Divider B strobe |

## Verification
Each of the eleven taps is measured over several consecutive intervals. This catches a wrong counter bit or a missing gate, and a scan over many cycles confirms the taps are nested. The dividers are tried with factor 1 on tap 0, mid-range factors on middle taps, factor 255, and a small factor on the slowest tap. This separates an off-by-one in the count from a wrong tap mux and from swapped field positions between A and B. Factor zero and reserved selects are watched for silence. A mid-count rewrite of A, timed from the write to the first pulse, shows whether the count restarts. The steady spacing of B across that same kind of write shows that the two dividers are independent.

// File: rtl/pwm_rate_pkg.sv
package pwm_rate_pkg;
  localparam int NUM_TAPS = 11;
  localparam int FAC_W    = 8;
  localparam int SEL_W    = 4;
  localparam int NUM_DIV  = 2;
  // Bit offset of each divider's field group inside the mode word
  localparam int DIV_STRIDE = 16;
  localparam int SEL_OFS    = 8;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic [FAC_W-1:0] fac;
  } div_cfg_t;
endpackage

// File: rtl/pwm_tap_chain.sv
module pwm_tap_chain #(
  parameter int NUM_TAPS = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic [NUM_TAPS-1:0] tap_o
);
  localparam int CW = (NUM_TAPS > 1) ? NUM_TAPS - 1 : 1;

  logic [CW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + CW'(1);
      run_q <= 1'b1;
    end
  end

  assign tap_o[0] = run_q;

  for (genvar k = 1; k < NUM_TAPS; k++) begin : g_tap
    assign tap_o[k] = run_q & (&cnt_q[k-1:0]);

    assert_tap_nested_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tap_o[k] |-> tap_o[k-1]);
    assert_tap_single_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      tap_o[k] |=> !tap_o[k]);
  end
endmodule

// File: rtl/pwm_lin_div.sv
module pwm_lin_div #(
  parameter int NUM_TAPS = 11,
  parameter int FAC_W    = 8,
  parameter int SEL_W    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_TAPS-1:0] tap_i,
  input  logic [FAC_W-1:0]    fac_i,
  input  logic [SEL_W-1:0]    sel_i,
  output logic                stb_o
);
  logic [FAC_W-1:0] fac_q;
  logic [SEL_W-1:0] sel_q;
  logic [FAC_W-1:0] cnt_q;
  logic             src;
  logic             cfg_chg;

  // Tap mux: a select with no matching tap yields no source pulses
  always_comb begin
    src = 1'b0;
    for (int i = 0; i < NUM_TAPS; i++) begin
      if (sel_q == SEL_W'(i)) src = tap_i[i];
    end
  end

  assign cfg_chg = (fac_i != fac_q) || (sel_i != sel_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fac_q <= '0;
      sel_q <= '0;
      cnt_q <= '0;
      stb_o <= 1'b0;
    end else if (cfg_chg) begin
      fac_q <= fac_i;
      sel_q <= sel_i;
      cnt_q <= '0;
      stb_o <= 1'b0;
    end else if (src && (fac_q != '0)) begin
      if (cnt_q == fac_q - FAC_W'(1)) begin
        cnt_q <= '0;
        stb_o <= 1'b1;
      end else begin
        cnt_q <= cnt_q + FAC_W'(1);
        stb_o <= 1'b0;
      end
    end else begin
      stb_o <= 1'b0;
    end
  end

  assert_stb_follows_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stb_o |-> $past(src));
  assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fac_q != '0) |-> (cnt_q < fac_q));
  assert_zero_factor_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fac_i == '0 && $past(fac_i) == '0) |-> !stb_o);
  assert_reserved_sel_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i >= SEL_W'(NUM_TAPS) && $past(sel_i) >= SEL_W'(NUM_TAPS)) |-> !stb_o);
endmodule

// File: rtl/pwm_rate_gen.sv
module pwm_rate_gen
  import pwm_rate_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [31:0]         mode_word,
  output logic [NUM_TAPS-1:0] tap_stb,
  output logic                stb_a,
  output logic                stb_b
);
  logic [NUM_DIV-1:0] div_stb;
  div_cfg_t           div_cfg [NUM_DIV];
  logic               unused_mode;

  assign unused_mode = ^{mode_word[15:12], mode_word[31:28]};

  pwm_tap_chain #(.NUM_TAPS(NUM_TAPS)) u_chain (
    .clk   (clk),
    .rst_n (rst_n),
    .tap_o (tap_stb)
  );

  for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
    localparam int BASE = g * DIV_STRIDE;
    assign div_cfg[g].fac = mode_word[BASE +: FAC_W];
    assign div_cfg[g].sel = mode_word[BASE + SEL_OFS +: SEL_W];

    pwm_lin_div #(
      .NUM_TAPS (NUM_TAPS),
      .FAC_W    (FAC_W),
      .SEL_W    (SEL_W)
    ) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .tap_i (tap_stb),
      .fac_i (div_cfg[g].fac),
      .sel_i (div_cfg[g].sel),
      .stb_o (div_stb[g])
    );
  end

  assign stb_a = div_stb[0];
  assign stb_b = div_stb[1];

  assert_reset_quiet_R9: assert property (@(posedge clk)
    !rst_n |=> (tap_stb[NUM_TAPS-1:1] == '0));
endmodule

// File: tb/pwm_rate_gen_tb_top.sv
`timescale 1ns/1ps
module pwm_rate_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] mode_word = '0;
  logic [10:0] tap_stb;
  logic        stb_a, stb_b;
  logic [12:0] sig;
  int n_checks = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  pwm_rate_gen dut_i (
    .clk(clk), .rst_n(rst_n), .mode_word(mode_word),
    .tap_stb(tap_stb), .stb_a(stb_a), .stb_b(stb_b)
  );

  assign sig = {stb_b, stb_a, tap_stb};
  localparam int IDX_A = 11;
  localparam int IDX_B = 12;

  function automatic logic [31:0] mk_cfg(int fa, int sa, int fb, int sb);
    return {4'h0, 4'(sb), 8'(fb), 4'h0, 4'(sa), 8'(fa)};
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Measure three consecutive pulse intervals on sig[idx]
  task automatic measure(int idx, int exp, string req);
    int last = 0;
    bit seen = 0;
    int got = 0;
    int limit = exp * 4 + 64;
    for (int n = 1; n <= limit; n++) begin
      @(negedge clk);
      if (sig[idx]) begin
        if (seen) begin
          check((n - last) == exp, req, n - last, exp);
          got++;
        end
        seen = 1;
        last = n;
        if (got == 3) break;
      end
    end
    if (got < 3) check(1'b0, req, got, 3);
  endtask

  task automatic expect_silent(int idx, int cycles, string req);
    int hits = 0;
    for (int n = 0; n < cycles; n++) begin
      @(negedge clk);
      if (sig[idx]) hits++;
    end
    check(hits == 0, req, hits, 0);
  endtask

  task automatic t_reset();
    int hits = 0;
    for (int n = 0; n < 8; n++) begin
      @(negedge clk);
      if (sig != '0) hits++;
    end
    check(hits == 0, "R9 reset quiet", hits, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_taps();
    for (int k = 0; k < 11; k++) measure(k, 1 << k, $sformatf("R1 tap%0d", k));
  endtask

  task automatic t_nesting();
    int bad = 0;
    for (int n = 0; n < 2100; n++) begin
      @(negedge clk);
      for (int k = 1; k < 11; k++)
        if (tap_stb[k] && !tap_stb[k-1]) bad++;
    end
    check(bad == 0, "R2 nesting", bad, 0);
  endtask

  task automatic t_div_a();
    @(negedge clk); mode_word = mk_cfg(1, 0, 0, 0);
    measure(IDX_A, 1, "R3 A f1 s0");
    @(negedge clk); mode_word = mk_cfg(5, 2, 0, 0);
    measure(IDX_A, 20, "R3 A f5 s2");
    @(negedge clk); mode_word = mk_cfg(7, 3, 0, 0);
    measure(IDX_A, 56, "R3 A f7 s3");
    @(negedge clk); mode_word = mk_cfg(255, 0, 0, 0);
    measure(IDX_A, 255, "R3 A f255 s0");
  endtask

  task automatic t_div_b();
    @(negedge clk); mode_word = mk_cfg(0, 0, 3, 10);
    measure(IDX_B, 3072, "R4 B f3 s10");
    @(negedge clk); mode_word = mk_cfg(0, 0, 9, 1);
    measure(IDX_B, 18, "R4 B f9 s1");
    expect_silent(IDX_A, 100, "R5 A factor zero");
  endtask

  task automatic t_zero_and_reserved();
    @(negedge clk); mode_word = mk_cfg(4, 0, 0, 0);
    expect_silent(IDX_B, 200, "R5 B factor zero");
    @(negedge clk); mode_word = mk_cfg(3, 11, 3, 15);
    expect_silent(IDX_A, 300, "R6 A sel 11");
    check(stb_b == 1'b0, "R6 B sel 15", stb_b, 0);
    expect_silent(IDX_B, 100, "R6 B sel 15");
  endtask

  task automatic t_restart();
    int n = 0;
    @(negedge clk); mode_word = mk_cfg(9, 0, 0, 0);
    repeat (13) @(negedge clk);
    mode_word = mk_cfg(6, 0, 0, 0);
    for (n = 1; n <= 40; n++) begin
      @(negedge clk);
      if (stb_a) break;
    end
    check(n == 7, "R7 restart delay", n, 7);
  endtask

  task automatic t_independent();
    int n = 0;
    @(negedge clk); mode_word = mk_cfg(4, 0, 50, 0);
    while (!stb_b) @(negedge clk);
    repeat (10) @(negedge clk);
    mode_word = mk_cfg(13, 2, 50, 0);
    for (n = 11; n <= 200; n++) begin
      @(negedge clk);
      if (stb_b) break;
    end
    check(n == 50, "R8 B spacing across A write", n, 50);
  endtask

  initial begin
    #1000000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    repeat (3) @(negedge clk);
    t_taps();
    t_nesting();
    t_div_a();
    t_div_b();
    t_zero_and_reserved();
    t_restart();
    t_independent();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule